// File: doc/BRIEF.md
# Variable-Length Byte-to-Word Packer

This block carries a byte stream over a 32-bit word channel. The encoder side takes up to four candidate bytes together with an offered count. It packs as many of them as the format allows into one word. Unused upper lanes are filled with length marker bytes, so the receiver can tell how many bytes a word carries. The encoder reports how many source bytes it actually consumed, and the caller advances its input pointer by exactly that amount. The decoder side takes a received word and returns the carried bytes, packed little-endian, together with a count from one to four.

A four-byte group is sent raw only when its upper lanes do not look like one of the length markers. Otherwise the encoder falls back to the three-byte form and leaves the fourth byte for the next word. An optional newline mode inserts a carriage return ahead of every line feed. In that mode a one-bit carry flag remembers when a word ended just after an inserted carriage return, so the line feed that follows in the next word is not preceded by a second one. Each direction has a registered output stage with a valid/ready handshake, and the two directions run independently.

Top module: `wordpack_codec`

## Requirements
- R1: A single packed byte b0 yields the word {8'h80, 8'h80, 8'h80, b0}, and the consumed count is 1.
- R2: Two packed bytes b0, b1 yield {8'h81, 8'h81, b1, b0}, and the consumed count is 2.
- R3: Three packed bytes yield {8'h82, b2, b1, b0}, and the consumed count is 3. The first byte always sits in bits 7:0.
- R4: Four offered bytes form the word {b3, b2, b1, b0} directly, with a consumed count of 4, when none of the collision patterns of R5 applies.
- R5: If b3 is 8'h82, or {b3, b2} is 16'h8181, or {b3, b2, b1} is 24'h808080, only three bytes are packed using the R3 form, and the consumed count is 3.
- R6: An offered count above 4 is treated as 4. An offered count of 0 is accepted but produces no output word.
- R7: The decoder reports count 1 when bits 31:8 are 24'h808080. Otherwise it reports 2 when bits 31:16 are 16'h8181, otherwise 3 when bits 31:24 are 8'h82, otherwise 4. The carried bytes appear little-endian on the output, and every lane above the count reads zero.
- R8: With enc_crlf_mode high, every line feed (8'h0A) is preceded by a carriage return (8'h0D) in the next output slot. The consumed count covers only the source bytes whose slots made it into the word. With the mode low, 8'h0A is packed like any other byte.
- R9: In newline mode, when an accepted word ends with an inserted carriage return, a line feed at the head of the next non-empty group is packed without another carriage return.
- R10: Each input ready is high when its output stage is empty or its output is being taken. A stalled output holds its valid, word and count stable. The encoder and decoder do not affect each other.
- R11: After reset both output valids are low, both input readies are high, and the newline carry flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_in_valid | input | 1 | Encoder group offered |
| enc_in_ready | output | 1 | Encoder group accepted this cycle |
| enc_in_bytes | input | 32 | Candidate bytes, first byte in bits 7:0 |
| enc_in_count | input | 3 | Number of valid candidate bytes |
| enc_crlf_mode | input | 1 | Insert carriage return before line feed |
| enc_out_valid | output | 1 | Packed word available |
| enc_out_ready | input | 1 | Consumer takes packed word |
| enc_out_word | output | 32 | Packed word |
| enc_out_used | output | 3 | Source bytes consumed by this word |
| dec_in_valid | input | 1 | Received word offered |
| dec_in_ready | output | 1 | Received word accepted this cycle |
| dec_in_word | input | 32 | Received word |
| dec_out_valid | output | 1 | Unpacked bytes available |
| dec_out_ready | input | 1 | Consumer takes unpacked bytes |
| dec_out_bytes | output | 32 | Unpacked bytes, first in bits 7:0, unused lanes zero |
| dec_out_count | output | 3 | Number of unpacked bytes, 1 to 4 |

## Verification
Directed groups of one to four ordinary bytes separate the four length forms. Groups whose top lanes equal 8'h82, 8'h81 8'h81 or 8'h80 8'h80 8'h80 show whether the three-byte fallback fires, and near-miss patterns such as 24'h808081 show that it fires only on exact matches. Sequences of line feeds, with newline mode on and off, check the carriage-return insertion. They also check the carry flag across word boundaries and across a reset. Random groups, biased toward marker bytes and line feeds and with counts from 0 to 7, are compared against a reference encoder and decoder in the bench, and a stalled output checks that each side holds its output without disturbing the other.

// File: rtl/wordpack_pkg.sv
package wordpack_pkg;
   localparam int LANES  = 4;
   localparam int BYTE_W = 8;
   localparam int WORD_W = LANES * BYTE_W;
   localparam int CNT_W  = $clog2(LANES + 1);

   localparam logic [3*BYTE_W-1:0] TAG_ONE   = 24'h808080;
   localparam logic [2*BYTE_W-1:0] TAG_TWO   = 16'h8181;
   localparam logic [BYTE_W-1:0]   TAG_THREE = 8'h82;

   typedef logic [LANES-1:0][BYTE_W-1:0] lanes_t;
   typedef logic [LANES-1:0][CNT_W-1:0]  cnts_t;
endpackage

// File: rtl/wp_lane_expand.sv
module wp_lane_expand
   import wordpack_pkg::*;
#(
   parameter int CR_CODE = 8'h0D,
   parameter int LF_CODE = 8'h0A
) (
   input  lanes_t            src,
   input  logic [CNT_W-1:0]  src_cnt,
   input  logic              crlf_on,
   input  logic              skip_in,
   output lanes_t            slot,
   output logic [CNT_W-1:0]  slot_n,
   output cnts_t             cons_at,
   output logic [LANES-1:0]  ins_cr
);
   localparam logic [BYTE_W-1:0] CR_B = BYTE_W'(CR_CODE);
   localparam logic [BYTE_W-1:0] LF_B = BYTE_W'(LF_CODE);

   always_comb begin
      int   idx;
      logic sk;
      idx     = 0;
      sk      = skip_in;
      slot    = '0;
      slot_n  = '0;
      cons_at = '0;
      ins_cr  = '0;
      for (int s = 0; s < LANES; s++) begin
         if (idx < int'(src_cnt)) begin
            if (crlf_on && (src[idx[1:0]] == LF_B) && !sk) begin
               slot[s]   = CR_B;
               ins_cr[s] = 1'b1;
               sk        = 1'b1;
            end else begin
               slot[s] = src[idx[1:0]];
               sk      = 1'b0;
               idx     = idx + 1;
            end
            cons_at[s] = CNT_W'(idx);
            slot_n     = CNT_W'(s + 1);
         end
      end
   end
endmodule

// File: rtl/wp_pack_core.sv
module wp_pack_core
   import wordpack_pkg::*;
(
   input  lanes_t            slot,
   input  logic [CNT_W-1:0]  slot_n,
   input  cnts_t             cons_at,
   input  logic [LANES-1:0]  ins_cr,
   output logic [WORD_W-1:0] word,
   output logic [CNT_W-1:0]  used,
   output logic              skip_next,
   output logic              any
);
   logic             clash;
   logic [CNT_W-1:0] n_eff;

   always_comb begin
      clash = (slot[3] == TAG_THREE) ||
              ({slot[3], slot[2]} == TAG_TWO) ||
              ({slot[3], slot[2], slot[1]} == TAG_ONE);
      n_eff = (slot_n == CNT_W'(LANES) && clash) ? CNT_W'(LANES - 1) : slot_n;
      case (n_eff)
         CNT_W'(1): word = {TAG_ONE, slot[0]};
         CNT_W'(2): word = {TAG_TWO, slot[1], slot[0]};
         CNT_W'(3): word = {TAG_THREE, slot[2], slot[1], slot[0]};
         CNT_W'(4): word = slot;
         default:   word = '0;
      endcase
      any       = (n_eff != '0);
      used      = any ? cons_at[n_eff - CNT_W'(1)] : '0;
      skip_next = any ? ins_cr[n_eff - CNT_W'(1)] : 1'b0;
   end
endmodule

// File: rtl/wp_unpack_core.sv
module wp_unpack_core
   import wordpack_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   output logic [WORD_W-1:0] bytes_o,
   output logic [CNT_W-1:0]  count
);
   always_comb begin
      if (word[WORD_W-1:BYTE_W] == TAG_ONE)
         count = CNT_W'(1);
      else if (word[WORD_W-1:2*BYTE_W] == TAG_TWO)
         count = CNT_W'(2);
      else if (word[WORD_W-1:3*BYTE_W] == TAG_THREE)
         count = CNT_W'(3);
      else
         count = CNT_W'(4);
      for (int l = 0; l < LANES; l++)
         bytes_o[l*BYTE_W +: BYTE_W] = (l < int'(count)) ? word[l*BYTE_W +: BYTE_W] : '0;
   end
endmodule

// File: rtl/wp_out_stage.sv
module wp_out_stage #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         up_take,
   input  logic         up_load,
   output logic         up_ready,
   input  logic [W-1:0] up_data,
   output logic         dn_valid,
   input  logic         dn_ready,
   output logic [W-1:0] dn_data
);
   assign up_ready = !dn_valid || dn_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dn_valid <= 1'b0;
         dn_data  <= '0;
      end else if (up_take && up_ready && up_load) begin
         dn_valid <= 1'b1;
         dn_data  <= up_data;
      end else if (dn_ready) begin
         dn_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/wordpack_codec.sv
module wordpack_codec
   import wordpack_pkg::*;
#(
   parameter int CR_CODE      = 8'h0D,
   parameter int LF_CODE      = 8'h0A,
   parameter bit CRLF_SUPPORT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        enc_in_valid,
   output logic        enc_in_ready,
   input  logic [31:0] enc_in_bytes,
   input  logic [2:0]  enc_in_count,
   input  logic        enc_crlf_mode,
   output logic        enc_out_valid,
   input  logic        enc_out_ready,
   output logic [31:0] enc_out_word,
   output logic [2:0]  enc_out_used,
   input  logic        dec_in_valid,
   output logic        dec_in_ready,
   input  logic [31:0] dec_in_word,
   output logic        dec_out_valid,
   input  logic        dec_out_ready,
   output logic [31:0] dec_out_bytes,
   output logic [2:0]  dec_out_count
);
   localparam int ENC_PAY = WORD_W + CNT_W;
   localparam int DEC_PAY = WORD_W + CNT_W;

   if (CR_CODE < 0 || CR_CODE >= (1 << BYTE_W)) begin : g_bad_cr
      $error("wordpack_codec: CR_CODE does not fit a byte");
   end
   if (LF_CODE < 0 || LF_CODE >= (1 << BYTE_W)) begin : g_bad_lf
      $error("wordpack_codec: LF_CODE does not fit a byte");
   end
   if (CR_CODE == LF_CODE) begin : g_bad_pair
      $error("wordpack_codec: CR_CODE and LF_CODE must differ");
   end

   lanes_t            src;
   logic [CNT_W-1:0]  cnt_c;
   lanes_t            slot;
   logic [CNT_W-1:0]  slot_n;
   cnts_t             cons_at;
   logic [LANES-1:0]  ins_cr;
   logic [WORD_W-1:0] pk_word;
   logic [CNT_W-1:0]  pk_used;
   logic              pk_skip;
   logic              pk_any;
   logic              skip_q;
   logic              enc_take;

   assign src   = enc_in_bytes;
   assign cnt_c = (enc_in_count > 3'(LANES)) ? CNT_W'(LANES) : enc_in_count;

   if (CRLF_SUPPORT) begin : g_crlf
      wp_lane_expand #(
         .CR_CODE (CR_CODE),
         .LF_CODE (LF_CODE)
      ) i_expand (
         .src     (src),
         .src_cnt (cnt_c),
         .crlf_on (enc_crlf_mode),
         .skip_in (skip_q),
         .slot    (slot),
         .slot_n  (slot_n),
         .cons_at (cons_at),
         .ins_cr  (ins_cr)
      );
   end else begin : g_plain
      assign slot   = src;
      assign slot_n = cnt_c;
      assign ins_cr = '0;
      for (genvar s = 0; s < LANES; s++) begin : g_cons
         assign cons_at[s] = CNT_W'(s + 1);
      end
   end

   wp_pack_core i_pack (
      .slot      (slot),
      .slot_n    (slot_n),
      .cons_at   (cons_at),
      .ins_cr    (ins_cr),
      .word      (pk_word),
      .used      (pk_used),
      .skip_next (pk_skip),
      .any       (pk_any)
   );

   assign enc_take = enc_in_valid && enc_in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         skip_q <= 1'b0;
      else if (enc_take && pk_any)
         skip_q <= pk_skip;
   end

   logic [ENC_PAY-1:0] enc_pay;

   wp_out_stage #(.W(ENC_PAY)) i_enc_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_take  (enc_in_valid),
      .up_load  (pk_any),
      .up_ready (enc_in_ready),
      .up_data  ({pk_used, pk_word}),
      .dn_valid (enc_out_valid),
      .dn_ready (enc_out_ready),
      .dn_data  (enc_pay)
   );

   assign {enc_out_used, enc_out_word} = enc_pay;

   logic [WORD_W-1:0]  up_bytes;
   logic [CNT_W-1:0]   up_count;
   logic [DEC_PAY-1:0] dec_pay;

   wp_unpack_core i_unpack (
      .word    (dec_in_word),
      .bytes_o (up_bytes),
      .count   (up_count)
   );

   wp_out_stage #(.W(DEC_PAY)) i_dec_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_take  (dec_in_valid),
      .up_load  (1'b1),
      .up_ready (dec_in_ready),
      .up_data  ({up_count, up_bytes}),
      .dn_valid (dec_out_valid),
      .dn_ready (dec_out_ready),
      .dn_data  (dec_pay)
   );

   assign {dec_out_count, dec_out_bytes} = dec_pay;
endmodule

// File: rtl/wordpack_codec_chk.sv
module wordpack_codec_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        enc_in_valid,
   input logic        enc_in_ready,
   input logic [31:0] enc_in_bytes,
   input logic [2:0]  enc_in_count,
   input logic        enc_crlf_mode,
   input logic        enc_out_valid,
   input logic        enc_out_ready,
   input logic [31:0] enc_out_word,
   input logic [2:0]  enc_out_used,
   input logic        dec_in_valid,
   input logic        dec_in_ready,
   input logic [31:0] dec_in_word,
   input logic        dec_out_valid,
   input logic        dec_out_ready,
   input logic [31:0] dec_out_bytes,
   input logic [2:0]  dec_out_count
);
   logic [2:0] offer_c;
   logic [2:0] mark_n;
   logic       enc_acc;

   assign offer_c = (enc_in_count > 3'd4) ? 3'd4 : enc_in_count;
   assign enc_acc = enc_in_valid && enc_in_ready;
   assign mark_n  = (enc_out_word[31:8] == 24'h808080) ? 3'd1 :
                    (enc_out_word[31:16] == 16'h8181)  ? 3'd2 :
                    (enc_out_word[31:24] == 8'h82)     ? 3'd3 : 3'd4;

   AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      enc_out_valid && !enc_out_ready |=> enc_out_valid && $stable(enc_out_word) && $stable(enc_out_used)); // R10
   AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      dec_out_valid && !dec_out_ready |=> dec_out_valid && $stable(dec_out_bytes) && $stable(dec_out_count)); // R10
   AST_DEC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      dec_in_valid && dec_in_ready |=> dec_out_valid); // R10
   AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      enc_acc && enc_in_count == 3'd0 |=> !enc_out_valid); // R6
   AST_USED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      enc_acc && enc_in_count != 3'd0 |=> enc_out_valid && enc_out_used >= 3'd1 && enc_out_used <= $past(offer_c)); // R6
   AST_PLAIN_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      enc_acc && enc_in_count != 3'd0 && !enc_crlf_mode |=> mark_n == enc_out_used); // R5
   AST_DEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      dec_out_valid |-> dec_out_count >= 3'd1 && dec_out_count <= 3'd4); // R7
endmodule

bind wordpack_codec wordpack_codec_chk i_chk (.*);

// File: tb/test_wordpack_codec.sv
module test_wordpack_codec;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        enc_in_valid, enc_in_ready, enc_crlf_mode;
   logic [31:0] enc_in_bytes;
   logic [2:0]  enc_in_count;
   logic        enc_out_valid, enc_out_ready;
   logic [31:0] enc_out_word;
   logic [2:0]  enc_out_used;
   logic        dec_in_valid, dec_in_ready;
   logic [31:0] dec_in_word;
   logic        dec_out_valid, dec_out_ready;
   logic [31:0] dec_out_bytes;
   logic [2:0]  dec_out_count;

   int n_chk  = 0;
   int n_fail = 0;
   bit model_skip = 1'b0;

   always #2 clk = ~clk;

   wordpack_codec i_wordpack_codec (.*);

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic void ref_enc(input logic [31:0] b, input int cnt_raw, input bit mode,
                                   input bit skip, output logic [31:0] w, output int used,
                                   output bit nskip, output bit any);
      logic [7:0] sl [4];
      int         srcn [4];
      bit         crf [4];
      int         n, k, c;
      bit         sk;
      logic [7:0] v;
      for (int i = 0; i < 4; i++) begin sl[i] = 8'h00; srcn[i] = 0; crf[i] = 1'b0; end
      c = (cnt_raw > 4) ? 4 : cnt_raw;
      n = 0; k = 0; sk = skip;
      while (n < 4 && k < c) begin
         v = b[8*k +: 8];
         if (mode && v == 8'h0A && !sk) begin
            sl[n] = 8'h0D; crf[n] = 1'b1; sk = 1'b1;
         end else begin
            sl[n] = v; crf[n] = 1'b0; sk = 1'b0; k++;
         end
         srcn[n] = k;
         n++;
      end
      any = (n > 0);
      if (n == 4 && (sl[3] == 8'h82 || (sl[3] == 8'h81 && sl[2] == 8'h81) ||
                     (sl[3] == 8'h80 && sl[2] == 8'h80 && sl[1] == 8'h80)))
         n = 3;
      case (n)
         1: w = {24'h808080, sl[0]};
         2: w = {16'h8181, sl[1], sl[0]};
         3: w = {8'h82, sl[2], sl[1], sl[0]};
         4: w = {sl[3], sl[2], sl[1], sl[0]};
         default: w = 32'h0;
      endcase
      used  = (n > 0) ? srcn[n-1] : 0;
      nskip = (n > 0) ? crf[n-1] : skip;
   endfunction

   function automatic void ref_dec(input logic [31:0] w, output logic [31:0] b, output int n);
      if (w[31:8] == 24'h808080) n = 1;
      else if (w[31:16] == 16'h8181) n = 2;
      else if (w[31:24] == 8'h82) n = 3;
      else n = 4;
      b = 32'h0;
      for (int i = 0; i < n; i++) b[8*i +: 8] = w[8*i +: 8];
   endfunction

   // lit: when set, the literal exp_w/exp_u are also compared
   task automatic enc_send(input logic [31:0] b, input int cnt, input bit mode, input string req,
                           input bit lit, input logic [31:0] exp_w, input int exp_u);
      logic [31:0] w; int u; bit ns, any;
      ref_enc(b, cnt, mode, model_skip, w, u, ns, any);
      @(negedge clk);
      enc_in_bytes = b; enc_in_count = 3'(cnt); enc_crlf_mode = mode; enc_in_valid = 1'b1;
      @(negedge clk);
      enc_in_valid = 1'b0;
      chk(enc_out_valid == any, req, 64'(enc_out_valid), 64'(any));
      if (any) begin
         chk(enc_out_word == w && enc_out_used == 3'(u), req, {29'h0, enc_out_used, enc_out_word}, {29'h0, 3'(u), w});
         if (lit) chk(w == exp_w && u == exp_u, {req, " literal"}, {29'h0, 3'(u), w}, {29'h0, 3'(exp_u), exp_w});
         model_skip = ns;
      end
   endtask

   task automatic dec_send(input logic [31:0] w, input string req, input bit lit, input int exp_n);
      logic [31:0] b; int n;
      ref_dec(w, b, n);
      @(negedge clk);
      dec_in_word = w; dec_in_valid = 1'b1;
      @(negedge clk);
      dec_in_valid = 1'b0;
      chk(dec_out_valid && dec_out_bytes == b && dec_out_count == 3'(n), req,
          {28'h0, dec_out_valid, dec_out_count, dec_out_bytes}, {28'h1, 3'(n), b});
      if (lit) chk(n == exp_n, {req, " literal"}, 64'(n), 64'(exp_n));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      model_skip = 1'b0;
      repeat (2) @(negedge clk);
      chk(!enc_out_valid && !dec_out_valid && enc_in_ready && dec_in_ready, "R11 reset state",
          {enc_out_valid, dec_out_valid, enc_in_ready, dec_in_ready}, 4'b0011);
      rst_n = 1'b1;
   endtask

   function automatic logic [7:0] pick_byte();
      case ($urandom % 8)
         0: return 8'h80;
         1: return 8'h81;
         2: return 8'h82;
         3: return 8'h0A;
         4: return 8'h0D;
         default: return 8'($urandom);
      endcase
   endfunction

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired R10 actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] b;
      void'($urandom(32'd20150129));
      rst_n = 1'b0;
      enc_in_valid = 0; enc_in_bytes = 0; enc_in_count = 0; enc_crlf_mode = 0; enc_out_ready = 1;
      dec_in_valid = 0; dec_in_word = 0; dec_out_ready = 1;
      do_reset();

      // Length forms
      enc_send(32'h00000041, 1, 0, "R1 one byte",   1, 32'h80808041, 1);
      enc_send(32'h00004241, 2, 0, "R2 two bytes",  1, 32'h81814241, 2);
      enc_send(32'h00434241, 3, 0, "R3 three bytes",1, 32'h82434241, 3);
      enc_send(32'h44434241, 4, 0, "R4 four raw",   1, 32'h44434241, 4);
      enc_send(32'h80808141, 4, 0, "R4 near miss",  1, 32'h80808141, 4);
      // Collisions
      enc_send(32'h82434241, 4, 0, "R5 tag three",  1, 32'h82434241, 3);
      enc_send(32'h81814241, 4, 0, "R5 tag two",    1, 32'h82814241, 3);
      enc_send(32'h80808041, 4, 0, "R5 tag one",    1, 32'h82808041, 3);
      // Counts
      enc_send(32'h44434241, 7, 0, "R6 count clamp",1, 32'h44434241, 4);
      enc_send(32'h44434241, 0, 0, "R6 zero count", 0, 32'h0, 0);
      // Newline mode
      enc_send(32'h630A6261, 4, 0, "R8 mode off",   1, 32'h630A6261, 4);
      enc_send(32'h63620A61, 4, 1, "R8 cr insert",  1, 32'h620A0D61, 3);
      enc_send(32'h0A0A0A0A, 4, 1, "R8 lf run",     1, 32'h0A0D0A0D, 2);
      enc_send(32'h0A636261, 4, 1, "R9 ends in cr", 1, 32'h0D636261, 3);
      enc_send(32'h0000000A, 1, 1, "R9 carried lf", 1, 32'h8080800A, 1);
      // Carry flag cleared by reset
      enc_send(32'h0A636261, 4, 1, "R9 set carry",  1, 32'h0D636261, 3);
      do_reset();
      enc_send(32'h0000000A, 1, 1, "R11 carry cleared", 1, 32'h81810A0D, 1);

      // Decoder directed
      dec_send(32'h80808041, "R7 one",  1, 1);
      dec_send(32'h81814241, "R7 two",  1, 2);
      dec_send(32'h82434241, "R7 three",1, 3);
      dec_send(32'h44434241, "R7 four", 1, 4);
      dec_send(32'h82808080, "R7 priority three", 1, 3);
      dec_send(32'h80808080, "R7 priority one",   1, 1);
      dec_send(32'h81818080, "R7 priority two",   1, 2);

      // Stall: encoder held, decoder unaffected
      @(negedge clk);
      enc_out_ready = 1'b0;
      enc_in_bytes = 32'h00000031; enc_in_count = 3'd1; enc_crlf_mode = 1'b0; enc_in_valid = 1'b1;
      @(negedge clk);
      enc_in_bytes = 32'h00003332; enc_in_count = 3'd2;
      chk(enc_out_valid && enc_out_word == 32'h80808031, "R10 first loaded", 64'(enc_out_word), 64'h80808031);
      chk(!enc_in_ready, "R10 ready low when stalled", 64'(enc_in_ready), 64'h0);
      dec_in_word = 32'h00434241; dec_in_valid = 1'b1;
      @(negedge clk);
      dec_in_valid = 1'b0;
      chk(dec_out_valid && dec_out_count == 3'd4, "R10 decoder independent", 64'(dec_out_count), 64'h4);
      chk(enc_out_valid && enc_out_word == 32'h80808031 && enc_out_used == 3'd1, "R10 hold",
          64'(enc_out_word), 64'h80808031);
      enc_out_ready = 1'b1;
      @(negedge clk);
      enc_in_valid = 1'b0;
      chk(enc_out_valid && enc_out_word == 32'h81813332 && enc_out_used == 3'd2, "R10 pass through",
          64'(enc_out_word), 64'h81813332);
      @(negedge clk);
      chk(!enc_out_valid, "R10 drained", 64'(enc_out_valid), 64'h0);

      // Random encoder (R1 R2 R3 R4 R5 R6 R8 R9)
      for (int it = 0; it < 600; it++) begin
         for (int l = 0; l < 4; l++) b[8*l +: 8] = pick_byte();
         enc_send(b, int'($urandom % 8), bit'($urandom % 2), "R5 R8 random enc", 0, 32'h0, 0);
      end
      // Random decoder (R7)
      for (int it = 0; it < 400; it++) begin
         for (int l = 0; l < 4; l++) b[8*l +: 8] = pick_byte();
         dec_send(b, "R7 random dec", 0, 0);
      end

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule